// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets logic running on a single clock read and write an external 8-bit-wide, 8192-word static RAM that has no clock of its own. The host raises a one-cycle request together with a read/write flag, an address and, for writes, a data byte. The controller then sequences the memory's select, enable, write and output strobes. It holds every strobe for a whole number of clock cycles. Each count is the ceiling of a nanosecond limit divided by `CLK_PERIOD_NS`, with a minimum of one cycle. When the access is complete it pulses `host_done` for one clock; for a read, `host_rdata` holds the captured byte from that cycle on.

The memory has two selects of opposite polarity: `mem_sel_n` (active low) and `mem_en` (active high). The controller always moves them together. Writes are ended by the write strobe: `mem_we_n` rises while both selects are still active, and the address is held for a short interval after that. The data bus is split into `mem_dq_out`, `mem_dq_in` and `mem_dq_oe`. The controller drives the bus only while the write strobe is low, and only after the output enable has been high long enough for the memory to release the bus.

Holding `host_retain` high puts the part into a low-power retention state: it is deselected, its outputs are released and the bus is not driven. When `host_retain` falls, the controller waits one full cycle time before any new access. A request that arrives during retention, during that recovery wait or while an access is running is held in a one-entry pending slot and is served next.

The state machine has seven states: `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD`, `ST_TURN`, `ST_RETAIN` and `ST_RECOVER`. Its transitions are:

| From | Condition | To |
|---|---|---|
| `ST_IDLE` | `host_retain` high | `ST_RETAIN` |
| `ST_IDLE` | request or pending entry present | `ST_SETUP` |
| `ST_SETUP` | after 1 cycle | `ST_STROBE` |
| `ST_STROBE` | count expires on a write | `ST_HOLD` |
| `ST_STROBE` | count expires on a read | `ST_TURN` |
| `ST_HOLD` | count expires | `ST_IDLE` |
| `ST_TURN` | count expires | `ST_IDLE` |
| `ST_RETAIN` | `host_retain` low | `ST_RECOVER` |
| `ST_RECOVER` | count expires | `ST_IDLE` |

Top module: `asram_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the memory is deselected (`mem_sel_n`=1, `mem_en`=0). In that state `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `host_done`=0.
- R2: `mem_sel_n` is low exactly when `mem_en` is high. `mem_we_n` and `mem_oe_n` go low only while both selects are active.
- R3: `mem_dq_oe` is high only while `mem_we_n` is low and `mem_oe_n` is high. It is high only after `mem_oe_n` has been high for at least ceil(10 ns / period) cycles. It is low in the cycle in which `mem_we_n` returns high.
- R4: Every write strobe (`mem_we_n` low) lasts at least ceil(35 ns / period) cycles. The byte on `mem_dq_out` is stable for at least ceil(22 ns / period) cycles before the strobe ends.
- R5: `mem_addr` does not change while the part is selected. On a write, the part is still selected in the cycle in which `mem_we_n` rises, which gives at least one cycle of address hold.
- R6: Every selected interval, read or write, lasts at least ceil(40 ns / period) cycles.
- R7: A read captures the memory byte only after the address has been stable for ceil(40 ns / period) cycles and `mem_oe_n` has been low for ceil(15 ns / period) cycles. `mem_oe_n` stays low for at least the second count. The captured byte equals the last byte written to that address.
- R8: `host_done` is high for exactly one clock per completed access. On a read, `host_rdata` is valid from that cycle on.
- R9: While in retention, the part is deselected, `mem_oe_n`=1 and `mem_dq_oe`=0. After `host_retain` falls, the part is not selected again for at least ceil(40 ns / period) cycles.
- R10: A request made during retention or recovery is neither lost nor started early. It is performed after recovery ends, with the address, data and direction given when it was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request |
| host_wr | input | 1 | 1 = write, 0 = read, sampled with `host_req` |
| host_addr | input | ADDR_W | Word address, sampled with `host_req` |
| host_wdata | input | DATA_W | Write byte, sampled with `host_req` |
| host_retain | input | 1 | Level request for the retention state |
| host_rdata | output | DATA_W | Last byte read |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_en | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Byte driven onto the data bus |
| mem_dq_in | input | DATA_W | Byte read from the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when high |

## Verification
The hardest case to reach from the ports is a request arriving while the part is in retention or recovery. That request must wait in the pending slot and then be replayed with its original fields after a full cycle-time gap. The bench reaches it with directed sequences. In one, the bench raises `host_retain`, issues a write while retention holds, and checks that the bus and selects stay quiet. It then drops `host_retain` and measures the gap before the next select. In the other, the bench issues a read in the first cycle after `host_retain` falls. Early-capture errors are exposed by a memory model that returns a poison byte until both the address and output-enable ages have been met. Randomized mixes over a narrow address range supply overwrite, read-after-write and write-after-read turnarounds.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN,
        ST_RETAIN,
        ST_RECOVER
    } asram_state_e;

    // Whole clock cycles covering a nanosecond limit, never below one.
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_tick_cnt.sv
module asram_tick_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A state entered with value N sees last in its N-th cycle.
    assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/asram_req_hold.sv
module asram_req_hold #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          start,
    output logic          pend_v,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata
);
    logic          pend_q;
    logic          pwr_q;
    logic [AW-1:0] paddr_q;
    logic [DW-1:0] pdata_q;
    logic          use_live;
    logic          store;

    // A live request is consumed directly only when nothing is waiting.
    assign use_live = start && !pend_q;
    assign store    = req && !use_live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pwr_q   <= 1'b0;
            paddr_q <= '0;
            pdata_q <= '0;
        end else if (store) begin
            pend_q  <= 1'b1;
            pwr_q   <= req_wr;
            paddr_q <= req_addr;
            pdata_q <= req_wdata;
        end else if (start) begin
            pend_q  <= 1'b0;
        end
    end

    assign pend_v    = pend_q;
    assign cmd_wr    = pend_q ? pwr_q   : req_wr;
    assign cmd_addr  = pend_q ? paddr_q : req_addr;
    assign cmd_wdata = pend_q ? pdata_q : req_wdata;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_WC_NS       = 40,
    parameter int T_WP_NS       = 35,
    parameter int T_DS_NS       = 22,
    parameter int T_AH_NS       = 3,
    parameter int T_RC_NS       = 40,
    parameter int T_ACC_NS      = 40,
    parameter int T_OE_NS       = 15,
    parameter int T_OHZ_NS      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_retain,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_en,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int N_WC   = ns_to_cycles(T_WC_NS,  CLK_PERIOD_NS);
    localparam int N_WP   = ns_to_cycles(T_WP_NS,  CLK_PERIOD_NS);
    localparam int N_DS   = ns_to_cycles(T_DS_NS,  CLK_PERIOD_NS);
    localparam int N_AH   = ns_to_cycles(T_AH_NS,  CLK_PERIOD_NS);
    localparam int N_RC   = ns_to_cycles(T_RC_NS,  CLK_PERIOD_NS);
    localparam int N_ACC  = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int N_OE   = ns_to_cycles(T_OE_NS,  CLK_PERIOD_NS);
    localparam int N_OHZ  = ns_to_cycles(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int N_CYC  = max2(N_WC, N_RC);
    localparam int N_SU   = 1;
    // Write strobe: pulse width, data setup, and what the cycle time still needs.
    localparam int N_WSTB = max2(max2(N_WP, N_DS), max2(N_WC - N_SU - N_AH, 1));
    // Read strobe: address access counted from SETUP, OE access from STROBE entry.
    localparam int N_RSTB = max2(max2(N_ACC - N_SU, N_OE), max2(N_RC - N_SU, 1));
    localparam int N_MAX  = max2(max2(N_WSTB, N_RSTB), max2(N_CYC, max2(N_OHZ, N_AH)));
    localparam int CW     = $clog2(N_MAX + 1);

    asram_state_e state_q, state_d;

    logic              tick_load;
    logic [CW-1:0]     tick_val;
    logic              tick_last;
    logic              pend_v;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              start;
    logic              capture;
    logic              done_d;
    logic              cur_wr_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [DATA_W-1:0] cur_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              sel_on, we_on, oe_on, drv_on;

    assign start = (state_q == ST_IDLE) && !host_retain && (host_req || pend_v);

    asram_req_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .req_wr    (host_wr),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .start     (start),
        .pend_v    (pend_v),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata)
    );

    asram_tick_cnt #(.W(CW)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tick_load),
        .load_val (tick_val),
        .last     (tick_last)
    );

    // Next state, counter reload and completion events.
    always_comb begin
        state_d   = state_q;
        tick_load = 1'b0;
        tick_val  = '0;
        capture   = 1'b0;
        done_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_retain) begin
                    state_d = ST_RETAIN;
                end else if (start) begin
                    state_d   = ST_SETUP;
                    tick_load = 1'b1;
                    tick_val  = CW'(N_SU);
                end
            end
            ST_SETUP: begin
                if (tick_last) begin
                    state_d   = ST_STROBE;
                    tick_load = 1'b1;
                    tick_val  = cur_wr_q ? CW'(N_WSTB) : CW'(N_RSTB);
                end
            end
            ST_STROBE: begin
                if (tick_last) begin
                    tick_load = 1'b1;
                    if (cur_wr_q) begin
                        state_d  = ST_HOLD;
                        tick_val = CW'(N_AH);
                    end else begin
                        state_d  = ST_TURN;
                        tick_val = CW'(N_OHZ);
                        capture  = 1'b1;
                        done_d   = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick_last) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_TURN: begin
                if (tick_last) state_d = ST_IDLE;
            end
            ST_RETAIN: begin
                if (!host_retain) begin
                    state_d   = ST_RECOVER;
                    tick_load = 1'b1;
                    tick_val  = CW'(N_CYC);
                end
            end
            ST_RECOVER: begin
                if (tick_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_wr_q    <= 1'b0;
            cur_addr_q  <= '0;
            cur_wdata_q <= '0;
            rdata_q     <= '0;
            done_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (start) begin
                cur_wr_q    <= cmd_wr;
                cur_addr_q  <= cmd_addr;
                cur_wdata_q <= cmd_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    // Memory-side strobes decoded from the state register.
    always_comb begin
        sel_on = 1'b0;
        we_on  = 1'b0;
        oe_on  = 1'b0;
        drv_on = 1'b0;
        unique case (state_q)
            ST_SETUP: sel_on = 1'b1;
            ST_STROBE: begin
                sel_on = 1'b1;
                we_on  = cur_wr_q;
                drv_on = cur_wr_q;
                oe_on  = !cur_wr_q;
            end
            ST_HOLD: sel_on = 1'b1;
            ST_IDLE, ST_TURN, ST_RETAIN, ST_RECOVER: sel_on = 1'b0;
            default: sel_on = 1'b0;
        endcase
    end

    assign mem_addr   = cur_addr_q;
    assign mem_sel_n  = !sel_on;
    assign mem_en     = sel_on;
    assign mem_we_n   = !we_on;
    assign mem_oe_n   = !oe_on;
    assign mem_dq_out = cur_wdata_q;
    assign mem_dq_oe  = drv_on;
    assign host_rdata = rdata_q;
    assign host_done  = done_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int N_CYC  = 10,
    parameter int N_WP   = 9,
    parameter int N_DS   = 6,
    parameter int N_OE   = 4,
    parameter int N_OHZ  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input asram_state_e      st,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_en,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              host_done
);
    localparam logic [15:0] MAXV = 16'hFFFF;

    logic [15:0] we_low, oe_high, oe_low, sel_cnt, since_ret;
    logic        seen_run;

    function automatic logic [15:0] inc(input logic [15:0] v);
        return (v == MAXV) ? v : v + 16'd1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low    <= '0;
            oe_high   <= MAXV;
            oe_low    <= '0;
            sel_cnt   <= '0;
            since_ret <= MAXV;
            seen_run  <= 1'b0;
        end else begin
            seen_run  <= 1'b1;
            we_low    <= !mem_we_n ? inc(we_low) : '0;
            oe_high   <= mem_oe_n ? inc(oe_high) : '0;
            oe_low    <= !mem_oe_n ? inc(oe_low) : '0;
            sel_cnt   <= !mem_sel_n ? inc(sel_cnt) : '0;
            since_ret <= (st == ST_RETAIN) ? '0 : inc(since_ret);
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_run |-> (mem_sel_n && !mem_en && mem_we_n && mem_oe_n && !mem_dq_oe && !host_done));

    p_sel_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n == !mem_en);

    p_strobe_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (!mem_sel_n && mem_en));

    p_no_fight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n && oe_high >= 16'(N_OHZ)));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low >= 16'(N_WP) && we_low >= 16'(N_DS)));

    p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_sel_n);

    p_cycle_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel_n) |-> sel_cnt >= 16'(N_CYC));

    p_oe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> oe_low >= 16'(N_OE));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    p_retain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETAIN) |-> (mem_sel_n && !mem_en && mem_oe_n && !mem_dq_oe));

    p_recover_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel_n) |-> since_ret >= 16'(N_CYC));
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_CYC  (N_CYC),
    .N_WP   (N_WP),
    .N_DS   (N_DS),
    .N_OE   (N_OE),
    .N_OHZ  (N_OHZ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (state_q),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_en     (mem_en),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .host_done  (host_done)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int PER = 4;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_CYC = cyc(40);
    localparam int E_WP  = cyc(35);
    localparam int E_DS  = cyc(22);
    localparam int E_ACC = cyc(40);
    localparam int E_OE  = cyc(15);
    localparam int E_OHZ = cyc(10);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_retain = 1'b0;
    logic [DW-1:0] host_rdata;
    logic          host_done;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_en, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_retain(host_retain),
        .host_rdata(host_rdata), .host_done(host_done), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_en(mem_en), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // Memory model contents and the bench's own expectation.
    logic [7:0] mdl[int];
    logic [7:0] exp_mem[int];

    function automatic logic [7:0] mdl_rd(input int a);
        return mdl.exists(a) ? mdl[a] : init_val(a);
    endfunction

    function automatic logic [7:0] expect_rd(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
    endfunction

    // Cycle-accurate memory model and timing monitor, sampled mid-cycle.
    bit         p_sel = 0, p_we_n = 1, p_done = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    int we_low = 0, dq_stab = 0, oe_high = 1000, oe_low = 0, sel_cyc = 0, addr_cyc = 0;

    always @(negedge clk) begin
        bit sel;
        sel = !mem_sel_n && mem_en;
        if (rst_n) begin
            if (mem_sel_n != !mem_en) chk(0, "R2 select pair", mem_sel_n, !mem_en);
            if ((!mem_we_n || !mem_oe_n) && !sel) chk(0, "R2 strobe while deselected", 0, 1);
            if (mem_dq_oe && (!mem_oe_n || oe_high < E_OHZ)) chk(0, "R3 bus fight", oe_high, E_OHZ);
            if (mem_dq_oe && mem_we_n) chk(0, "R3 drive outside strobe", mem_we_n, 0);
            if (sel && p_sel && mem_addr != p_addr) chk(0, "R5 address moved", mem_addr, p_addr);
            if (host_done && p_done) chk(0, "R8 done wider than one", 2, 1);
            if (p_sel && !p_we_n && mem_we_n) begin
                chk(we_low >= E_WP, "R4 write pulse", we_low, E_WP);
                chk(dq_stab >= E_DS, "R4 data setup", dq_stab, E_DS);
                chk(sel, "R5 address hold", sel, 1);
                chk(!mem_dq_oe, "R3 release", mem_dq_oe, 0);
                mdl[int'(p_addr)] = p_dq;
            end
            if (p_sel && !sel) chk(sel_cyc >= E_CYC, "R6 cycle length", sel_cyc, E_CYC);
        end
        we_low   = !mem_we_n ? we_low + 1 : 0;
        dq_stab  = mem_dq_oe ? ((p_we_n == 0 && mem_dq_out == p_dq) ? dq_stab + 1 : 1) : 0;
        oe_high  = mem_oe_n ? oe_high + 1 : 0;
        oe_low   = !mem_oe_n ? oe_low + 1 : 0;
        sel_cyc  = sel ? sel_cyc + 1 : 0;
        addr_cyc = sel ? ((p_sel && mem_addr == p_addr) ? addr_cyc + 1 : 1) : 0;
        mem_dq_in = (sel && !mem_oe_n && addr_cyc >= E_ACC && oe_low >= E_OE)
                    ? mdl_rd(int'(mem_addr)) : 8'hEE;
        p_sel  = sel;
        p_we_n = mem_we_n;
        p_addr = mem_addr;
        p_dq   = mem_dq_out;
        p_done = host_done;
    end

    task automatic wait_done(input string rq);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (host_done) return;
        end
        chk(0, rq, 0, 1);
    endtask

    task automatic issue(input bit wr, input int a, input logic [7:0] d);
        @(negedge clk);
        host_req   = 1'b1;
        host_wr    = wr;
        host_addr  = AW'(a);
        host_wdata = d;
        @(negedge clk);
        host_req   = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        issue(1'b1, a, d);
        wait_done("R8 write done missing");
        exp_mem[a] = d;
    endtask

    task automatic do_read(input int a, input string rq);
        issue(1'b0, a, 8'h00);
        wait_done("R8 read done missing");
        chk(host_rdata == expect_rd(a), rq, host_rdata, expect_rd(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int gap;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(mem_sel_n && !mem_en && mem_we_n && mem_oe_n && !mem_dq_oe && !host_done,
            "R1 reset outputs", {mem_sel_n, mem_en, mem_we_n, mem_oe_n, mem_dq_oe, host_done}, 6'b101100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_sel_n && !mem_en && !host_done, "R1 after release", {mem_sel_n, mem_en}, 2'b10);

        // R7: unwritten word returns its initial contents; boundaries
        do_read(100, "R7 read initial");
        do_write(0, 8'hA5);
        do_write(8191, 8'h3C);
        do_read(0, "R7 read low bound");
        do_read(8191, "R7 read high bound");
        // R3: write right after read exercises turnaround
        do_write(0, 8'hFF);
        do_read(0, "R7 read after overwrite");
        do_write(1, 8'h00);
        do_read(1, "R7 read zero byte");

        // R8: done is a single cycle
        issue(1'b0, 0, 8'h00);
        wait_done("R8 done missing");
        @(negedge clk);
        chk(!host_done, "R8 done single cycle", host_done, 0);

        // R9/R10: write requested during retention
        @(negedge clk);
        host_retain = 1'b1;
        repeat (4) @(negedge clk);
        chk(mem_sel_n && !mem_en && mem_oe_n && !mem_dq_oe, "R9 retention quiet",
            {mem_sel_n, mem_en, mem_oe_n, mem_dq_oe}, 4'b1010);
        issue(1'b1, 77, 8'h9D);
        gap = 0;
        repeat (20) begin
            @(negedge clk);
            if (!mem_sel_n || host_done || mem_dq_oe) gap++;
        end
        chk(gap == 0, "R10 held during retention", gap, 0);
        host_retain = 1'b0;
        gap = 0;
        while (mem_sel_n && gap < 200) begin
            @(negedge clk);
            gap++;
        end
        chk(gap >= E_CYC && gap < 200, "R9 recovery gap", gap, E_CYC);
        wait_done("R10 pending write done");
        exp_mem[77] = 8'h9D;
        do_read(77, "R10 pending write landed");

        // R10: read requested in the first cycle of recovery
        @(negedge clk);
        host_retain = 1'b1;
        repeat (3) @(negedge clk);
        host_retain = 1'b0;
        issue(1'b0, 8191, 8'h00);
        wait_done("R10 recovery read done");
        chk(host_rdata == expect_rd(8191), "R10 read during recovery", host_rdata, expect_rd(8191));

        // Random mix over a narrow window to force overwrites
        for (int i = 0; i < 300; i++) begin
            int a;
            a = int'($urandom_range(0, 31)) + ((i % 2) * 8160);
            if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom()));
            else do_read(a, "R7 random read");
        end

        repeat (5) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule